// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level page table stored in ordinary memory. A caller presents one request at a time, with the virtual address and a flag that marks the access as a store. The walker reads a directory entry at the location given by a base address input. It then reads the second-level entry that this directory entry points to, and returns either the physical address or a fault code.

On a successful walk the walker keeps the leaf entry's status current. It marks the entry as accessed and, for stores, as modified. It writes the entry back only when one of those bits was not already set. The memory side is a plain single-word port. A read strobe in one cycle returns its word on the read data input in the next cycle, and a write strobe completes in its own cycle. No caching of translations is done.

Top module: `pt_walker`

## Requirements
- R1: The first memory access of a walk is a read at `dir_base + 4*va[31:22]`, using the `dir_base` value captured when the request is accepted.
- R2: When the directory entry has bit 0 (present) set, the second access is a read at `{dir_entry[31:12], va[21:12], 2'b00}`.
- R3: A directory entry with bit 0 clear ends the walk after one read, with `resp_fault` = 1 and `resp_paddr` = 0.
- R4: A table entry with bit 0 clear ends the walk with `resp_fault` = 2, `resp_paddr` = 0 and no memory write.
- R5: A store to a present table entry with bit 1 (writable) clear ends with `resp_fault` = 3, `resp_paddr` = 0 and no memory write.
- R6: A walk that passes both checks returns `resp_fault` = 0 and `resp_paddr` = `{table_entry[31:12], va[11:0]}`.
- R7: On success the leaf entry gains bit 5 (accessed), and also bit 6 (dirty) for stores. It is written to the table entry address in exactly one write when this changes it, and is not written otherwise.
- R8: `busy` rises in the cycle after a request is accepted and stays high up to and including the response cycle. `req_valid` is ignored while `busy` is high.
- R9: `resp_valid` is a one-cycle pulse. Counted in cycles after the accepting edge, it comes 3 cycles later for a directory fault, 5 for a table, protection or no-update success, and 6 when a write-back happens.
- R10: During reset, `busy`, `resp_valid`, `mem_rd` and `mem_wr` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 for a store access, 0 for a load |
| dir_base | input | 32 | Byte address of the top-level directory |
| busy | output | 1 | A walk is in progress |
| resp_valid | output | 1 | Response pulse |
| resp_paddr | output | 32 | Physical address, 0 on a fault |
| resp_fault | output | 2 | 0 ok, 1 directory absent, 2 page absent, 3 write protected |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Word for the read issued in the previous cycle |

## Verification
Each walk's result is due at a fixed cycle. It comes 3 cycles after the accepting edge for a missing directory entry, 5 cycles after for table, protection and no-update outcomes, and 6 cycles after when the leaf is written back. The bench predicts which of these applies from its own copy of memory before it issues the request. It counts falling edges from acceptance to the response and compares that count with the prediction, and it checks `busy` on every edge in between. Read addresses, the number of writes and the final leaf word are compared once the response appears. One cycle later the bench confirms that the response pulse has ended.

// File: rtl/pt_walker.sv
module pt_walker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_vaddr,
  input  logic        req_write,
  input  logic [31:0] dir_base,
  output logic        busy,
  output logic        resp_valid,
  output logic [31:0] resp_paddr,
  output logic [1:0]  resp_fault,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata
);
  localparam int BIT_P = 0;
  localparam int BIT_W = 1;
  localparam int BIT_A = 5;
  localparam int BIT_D = 6;

  typedef enum logic [2:0] {S_IDLE, S_DREQ, S_DWAIT, S_TREQ, S_TWAIT, S_WB, S_RESP} st_t;
  st_t st;

  logic [31:0] va, base_q, leaf, paddr;
  logic [19:0] dfrm;
  logic        wr;
  logic [1:0]  fault;
  logic [31:0] upd;

  assign upd = mem_rdata | (32'd1 << BIT_A) | (wr ? (32'd1 << BIT_D) : 32'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; va <= '0; base_q <= '0; leaf <= '0; paddr <= '0;
      dfrm <= '0; wr <= 1'b0; fault <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va <= req_vaddr; wr <= req_write; base_q <= dir_base;
          fault <= '0; paddr <= '0; st <= S_DREQ;
        end
        S_DREQ: st <= S_DWAIT;
        S_DWAIT: if (!mem_rdata[BIT_P]) begin
          fault <= 2'd1; st <= S_RESP;
        end else begin
          dfrm <= mem_rdata[31:12]; st <= S_TREQ;
        end
        S_TREQ: st <= S_TWAIT;
        S_TWAIT: if (!mem_rdata[BIT_P]) begin
          fault <= 2'd2; st <= S_RESP;
        end else if (wr && !mem_rdata[BIT_W]) begin
          fault <= 2'd3; st <= S_RESP;
        end else begin
          paddr <= {mem_rdata[31:12], va[11:0]};
          leaf  <= upd;
          st    <= (upd != mem_rdata) ? S_WB : S_RESP;
        end
        S_WB:   st <= S_RESP;
        S_RESP: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy       = (st != S_IDLE);
  assign resp_valid = (st == S_RESP);
  assign resp_paddr = paddr;
  assign resp_fault = fault;
  assign mem_rd     = (st == S_DREQ) || (st == S_TREQ);
  assign mem_wr     = (st == S_WB);
  assign mem_wdata  = leaf;
  assign mem_addr   = (st == S_DREQ) ? base_q + {20'd0, va[31:22], 2'b00}
                                     : {dfrm, va[21:12], 2'b00};

  p_resp_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> busy);
  p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid) |=> busy);
  p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);
  p_fault_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_fault != 2'd0) |-> resp_paddr == 32'd0);
  p_wb_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (mem_addr == $past(mem_addr, 2) && $past(mem_rd, 2)));
  p_wb_acc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> mem_wdata[BIT_A]);
  p_strobe_r10: assert property (@(posedge clk)
    !rst_n |=> (!mem_rd && !mem_wr && !resp_valid));
endmodule

// File: tb/sim_pt_walker.sv
module sim_pt_walker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic req_write = 1'b0;
  logic [31:0] dir_base = '0;
  logic busy, resp_valid, mem_rd, mem_wr;
  logic [31:0] resp_paddr, mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic [1:0] resp_fault;

  always #4 clk = ~clk;

  pt_walker u0 (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_write(req_write), .dir_base(dir_base), .busy(busy), .resp_valid(resp_valid),
    .resp_paddr(resp_paddr), .resp_fault(resp_fault), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  logic [31:0] mem [0:8191];
  int rd_cnt = 0, wr_cnt = 0;
  logic [31:0] rd_a0 = '0, rd_a1 = '0;

  always @(posedge clk) begin
    if (mem_rd) begin
      mem_rdata <= mem[mem_addr[14:2]];
      rd_cnt <= rd_cnt + 1; rd_a1 <= rd_a0; rd_a0 <= mem_addr;
    end
    if (mem_wr) begin
      mem[mem_addr[14:2]] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
  end

  int checks = 0, fails = 0;
  int cyc = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] table_frame(input int k);
    int fr [6] = '{1, 2, 3, 5, 6, 7};
    return 20'(fr[k % 6]);
  endfunction

  function automatic logic [31:0] rnd_status(input int pct_present);
    logic [31:0] s = 32'($urandom) & 32'h0000_0FFE;
    if (int'($urandom_range(99)) < pct_present) s[0] = 1'b1;
    return s;
  endfunction

  task automatic fill_memory();
    for (int i = 0; i < 1024; i++) begin
      mem[i]        = {table_frame(int'($urandom_range(5))), rnd_status(85)[11:0]};
      mem[4096 + i] = {table_frame(int'($urandom_range(5))), rnd_status(85)[11:0]};
    end
    for (int k = 0; k < 6; k++)
      for (int i = 0; i < 1024; i++)
        mem[int'(table_frame(k)) * 1024 + i] = {20'($urandom), rnd_status(80)[11:0]};
  endtask

  task automatic walk(input logic [31:0] va, input bit w, input bit hold);
    logic [31:0] dira, de, ta, te, nl, epa;
    logic [1:0] ef;
    int elat, ereads, ewr, lat, rc, wc;
    bit busyok;
    dira = dir_base + {20'd0, va[31:22], 2'b00};
    de = mem[dira[14:2]];
    ta = {de[31:12], va[21:12], 2'b00};
    te = 32'd0; nl = 32'd0; epa = 32'd0; ewr = 0;
    if (!de[0]) begin ef = 2'd1; elat = 3; ereads = 1; end
    else begin
      te = mem[ta[14:2]]; ereads = 2; elat = 5; nl = te;
      if (!te[0]) ef = 2'd2;
      else if (w && !te[1]) ef = 2'd3;
      else begin
        ef = 2'd0; epa = {te[31:12], va[11:0]};
        nl = te | 32'h20 | (w ? 32'h40 : 32'h0);
        if (nl != te) begin ewr = 1; elat = 6; end
      end
    end
    @(negedge clk);
    chk(busy == 1'b0, "R8 idle before request", 32'(busy), 0);
    rc = rd_cnt; wc = wr_cnt;
    req_valid = 1'b1; req_vaddr = va; req_write = w;
    @(posedge clk);
    @(negedge clk);
    if (!hold) req_valid = 1'b0;
    else req_vaddr = ~va;
    lat = 1; busyok = 1;
    while (!resp_valid && lat < 20) begin
      if (!busy) busyok = 0;
      @(negedge clk);
      lat++;
    end
    req_valid = 1'b0;
    chk(busyok && busy, "R8 busy held through walk", 32'(busy), 1);
    chk(lat == elat, "R9 response latency", 32'(lat), 32'(elat));
    chk(resp_fault == ef, "R3 R4 R5 R6 fault code", 32'(resp_fault), 32'(ef));
    chk(resp_paddr == epa, "R6 physical address", resp_paddr, epa);
    chk(rd_cnt - rc == ereads, "R3 read count", 32'(rd_cnt - rc), 32'(ereads));
    if (ereads == 2) begin
      chk(rd_a1 == dira, "R1 directory entry address", rd_a1, dira);
      chk(rd_a0 == ta, "R2 table entry address", rd_a0, ta);
      chk(mem[ta[14:2]] == nl, "R7 R5 leaf contents", mem[ta[14:2]], nl);
    end else
      chk(rd_a0 == dira, "R1 directory entry address", rd_a0, dira);
    chk(wr_cnt - wc == ewr, "R7 write count", 32'(wr_cnt - wc), 32'(ewr));
    @(negedge clk);
    chk(!resp_valid && !busy, "R9 single response pulse", 32'(resp_valid), 0);
    if (hold) begin
      @(negedge clk); @(negedge clk);
      chk(!busy && rd_cnt - rc == ereads, "R8 request during walk ignored", 32'(busy), 0);
    end
  endtask

  initial begin
    while (!done && cyc < 190000) begin @(posedge clk); cyc++; end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    fill_memory();
    repeat (3) @(negedge clk);
    chk(!busy && !resp_valid && !mem_rd && !mem_wr, "R10 reset outputs",
        {28'd0, busy, resp_valid, mem_rd, mem_wr}, 0);
    rst_n = 1'b1;

    dir_base = 32'h0;
    mem[5]  = 32'h0000_0000;
    walk({10'd5, 10'd1, 12'h123}, 1'b0, 1'b0);
    mem[6]  = 32'h0000_1001;
    mem[1024 + 7] = 32'hABCDE_0FE & 32'hFFFF_FFFE;
    walk({10'd6, 10'd7, 12'h456}, 1'b0, 1'b0);
    mem[1024 + 8] = 32'h12345_001;
    walk({10'd6, 10'd8, 12'h789}, 1'b1, 1'b0);
    walk({10'd6, 10'd8, 12'h789}, 1'b0, 1'b0);
    walk({10'd6, 10'd8, 12'hFFF}, 1'b0, 1'b0);
    mem[1024 + 9] = 32'h54321_023;
    walk({10'd6, 10'd9, 12'h000}, 1'b1, 1'b0);
    walk({10'd6, 10'd9, 12'h001}, 1'b1, 1'b0);
    mem[1024 + 10] = 32'h0F0F0_003;
    walk({10'd6, 10'd10, 12'hABC}, 1'b0, 1'b1);

    dir_base = 32'h4000;
    mem[4096 + 1023] = 32'h0000_7001;
    mem[7 * 1024 + 1023] = 32'hFFFFF_063;
    walk(32'hFFFF_FFFF, 1'b1, 1'b0);

    for (int n = 0; n < 400; n++) begin
      dir_base = ($urandom_range(1) == 0) ? 32'h0 : 32'h4000;
      walk($urandom, 1'($urandom), n % 37 == 0);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule